// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This engine moves received frames from a byte-wide receive FIFO into memory. It follows a list of four-word descriptors that the host prepares. It fetches one descriptor at a time and packs incoming bytes into 32-bit words. It writes those words into the one or two buffers the descriptor names. It then hands the descriptor back to the host by writing a status word with the ownership flag cleared. When the frame qualifies, it first writes a capture timestamp into words 2 and 3.

A frame larger than one descriptor continues in the following descriptor. The next descriptor sits either at the next 16-byte slot (ring mode, with a wrap flag) or at a pointer held in word 3 (chain mode). When the engine meets a descriptor the host still owns, it parks and raises a buffer-unavailable flag. It resumes on a poll strobe or on the start of a new frame.

Descriptor layout. Word 0 holds:
- bit 31: ownership (1 means the engine owns it)
- bits 29:16: frame length
- bit 9: first segment
- bit 8: last segment
- bit 7: timestamp written

Word 1 holds:
- bit 31: end of ring
- bit 30: chain mode
- bits 28:16: buffer 2 size in bytes
- bits 12:0: buffer 1 size in bytes

Word 2 holds the buffer 1 address. Word 3 holds the buffer 2 address in ring mode, or the next descriptor address in chain mode.

Top module: `rx_desc_dma`

## Requirements
- R1: A rising edge on `run_en` makes the engine read word 0 at `list_base`. A descriptor whose word 0 bit 31 is 1 is read in full (words 0 to 3), and then frame bytes are accepted (`in_ready` high).
- R2: A fetched word 0 with bit 31 equal to 0 parks the engine with `buf_unavail` high and `in_ready` low. The descriptor is left unmodified.
- R3: A `poll_kick` pulse while parked clears `buf_unavail` and re-reads the same descriptor.
- R4: While parked between frames, a valid byte marked `in_sof` also wakes the engine. That frame is then stored in the re-read descriptor.
- R5: In ring mode bytes fill buffer 1 and then buffer 2, so the capacity is the sum of both sizes. In chain mode (word 1 bit 30 set) only buffer 1 is used.
- R6: When a descriptor fills before the end-of-frame byte, its word 0 is written with bit 31 equal to 0 and bit 8 equal to 0. Bit 9 is 1 only on the descriptor that holds the first byte, and the length field is 0. The frame continues in the next descriptor.
- R7: The descriptor holding the end-of-frame byte gets word 0 with bit 31 equal to 0 and bit 8 equal to 1. Bits 29:16 hold the total frame length in bytes.
- R8: When `ts_enable` is high and `in_ts_hit` accompanies the end-of-frame byte, words 2 and 3 are written with the low and high halves of `ts_value` captured at the start-of-frame byte, and word 0 bit 7 is 1. Otherwise words 2 and 3 are not written and bit 7 is 0.
- R9: In ring mode the next descriptor is at the current address plus 16, or at `list_base` when word 1 bit 31 is set. In chain mode the next descriptor is the address in word 3.
- R10: After reset, and after `run_en` falls (once any open memory access completes), `mem_req` and `in_ready` are low and `buf_unavail` is 0.
- R11: Bytes are packed little-endian into words; a final partial word is padded with zero bytes. The low two bits of each size field are ignored.
- R12: Once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values until `mem_gnt` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start (rising edge) / stop (low) control |
| poll_kick | input | 1 | One-cycle poll demand strobe |
| ts_enable | input | 1 | Timestamp write-back enable |
| list_base | input | AW | Address of the first descriptor / ring wrap target |
| ts_value | input | 64 | Free-running timestamp |
| in_valid | input | 1 | Receive byte valid |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ts_hit | input | 1 | Frame qualifies for timestamping (with end byte) |
| in_ready | output | 1 | Engine takes the byte on this edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| buf_unavail | output | 1 | Parked on a host-owned descriptor |

## Verification
The bench builds the engine with the default 32-bit address width against a 1 KB word memory. Its grant is random, so every request waits a varying number of cycles. The buffer sizes are only 8 to 18 bytes. With buffers that small, single- and multi-descriptor frames, the move into buffer 2, the ring wrap, the chain pointer and both wake-up paths all occur within a few hundred cycles. One size field has non-zero low bits, which brings the size truncation within reach.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int unsigned SLOT_BYTES = 16;
    localparam int unsigned LEN_W      = 14;
    localparam int unsigned SZW_W      = 11;   // size field in whole words

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3,
        S_RUN, S_WRB, S_TS2, S_TS3, S_CL0, S_SUSP
    } seq_state_e;

    typedef struct packed {
        logic             own;
        logic             rsv;
        logic [LEN_W-1:0] flen;
        logic [5:0]       pad_a;
        logic             first;
        logic             last;
        logic             tsw;
        logic [6:0]       pad_b;
    } status_word_t;

    function automatic logic [LEN_W-1:0] usable_bytes(input logic [SZW_W-1:0] words);
        return {1'b0, words, 2'b00};
    endfunction

    function automatic logic [31:0] close_word(input logic [LEN_W-1:0] len,
                                               input logic first, input logic last,
                                               input logic tsw);
        status_word_t s;
        s       = '0;
        s.flen  = last ? len : '0;
        s.first = first;
        s.last  = last;
        s.tsw   = last & tsw;
        return s;
    endfunction

endpackage

// File: rtl/rxdma_nextdesc.sv
module rxdma_nextdesc #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] link,
    input  logic          wrap,
    input  logic          chain,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STRIDE = AW'(rxdma_pkg::SLOT_BYTES);

    always_comb begin
        if (chain)     nxt = link;
        else if (wrap) nxt = base;
        else           nxt = cur + STRIDE;
    end
endmodule

// File: rtl/rxdma_bufaddr.sv
module rxdma_bufaddr #(
    parameter int unsigned AW    = 32,
    parameter int unsigned OFF_W = 14
) (
    input  logic [AW-1:0]    buf1,
    input  logic [AW-1:0]    buf2,
    input  logic [OFF_W-1:0] size1,
    input  logic [OFF_W-1:0] wptr,
    output logic [AW-1:0]    addr
);
    always_comb begin
        if (wptr < size1) addr = buf1 + AW'(wptr);
        else              addr = buf2 + AW'(wptr - size1);
    end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
    import rxdma_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          poll_kick,
    input  logic          ts_enable,
    input  logic [AW-1:0] list_base,
    input  logic [63:0]   ts_value,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_ts_hit,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic [31:0]   mem_rdata,
    output logic          buf_unavail
);
    localparam logic [AW-1:0] W1_OFS = AW'(4);
    localparam logic [AW-1:0] W2_OFS = AW'(8);
    localparam logic [AW-1:0] W3_OFS = AW'(12);

    seq_state_e        st;
    logic [AW-1:0]     cur, b1a, b2a, nxt, wr_addr;
    logic              d_wrap, d_chain;
    logic [SZW_W-1:0]  sz1w, sz2w;
    logic [LEN_W-1:0]  c1, cap, off, wptr, flen;
    logic [1:0]        lane;
    logic [31:0]       wbuf;
    logic [63:0]       ts_cap;
    logic              first_seg, eof_seen, ts_q, mid, start_d;
    logic              accept, done, word_end;

    always_comb begin
        c1  = usable_bytes(sz1w);
        cap = d_chain ? c1 : c1 + usable_bytes(sz2w);
    end

    rxdma_nextdesc #(.AW(AW)) u_next (
        .cur(cur), .base(list_base), .link(b2a),
        .wrap(d_wrap), .chain(d_chain), .nxt(nxt)
    );

    rxdma_bufaddr #(.AW(AW), .OFF_W(LEN_W)) u_baddr (
        .buf1(b1a), .buf2(b2a), .size1(c1), .wptr(wptr), .addr(wr_addr)
    );

    assign in_ready = (st == S_RUN) && run_en;
    assign accept   = in_valid && in_ready;
    assign word_end = (lane == 2'd3) || in_eof || (off + LEN_W'(1) == cap);

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = '0;
        unique case (st)
            S_RD0: ;
            S_RD1: mem_addr = cur + W1_OFS;
            S_RD2: mem_addr = cur + W2_OFS;
            S_RD3: mem_addr = cur + W3_OFS;
            S_WRB: begin mem_we = 1'b1; mem_addr = wr_addr; mem_wdata = wbuf; end
            S_TS2: begin mem_we = 1'b1; mem_addr = cur + W2_OFS; mem_wdata = ts_cap[31:0]; end
            S_TS3: begin mem_we = 1'b1; mem_addr = cur + W3_OFS; mem_wdata = ts_cap[63:32]; end
            S_CL0: begin
                mem_we    = 1'b1;
                mem_wdata = close_word(flen, first_seg, eof_seen, ts_q);
            end
            default: mem_req = 1'b0;
        endcase
    end

    assign done = mem_req && mem_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;  cur <= '0;  b1a <= '0;  b2a <= '0;
            d_wrap <= 1'b0;  d_chain <= 1'b0;  sz1w <= '0;  sz2w <= '0;
            off <= '0;  wptr <= '0;  flen <= '0;  lane <= '0;  wbuf <= '0;
            ts_cap <= '0;  first_seg <= 1'b0;  eof_seen <= 1'b0;  ts_q <= 1'b0;
            mid <= 1'b0;  start_d <= 1'b0;  buf_unavail <= 1'b0;
        end else begin
            start_d <= run_en;
            if (!run_en && st != S_IDLE && (!mem_req || mem_gnt)) begin
                st          <= S_IDLE;
                buf_unavail <= 1'b0;
            end else begin
                unique case (st)
                    S_IDLE: if (run_en && !start_d) begin
                        cur <= list_base;  mid <= 1'b0;  eof_seen <= 1'b0;
                        st  <= S_RD0;
                    end
                    S_RD0: if (done) begin
                        if (mem_rdata[31]) st <= S_RD1;
                        else begin st <= S_SUSP; buf_unavail <= 1'b1; end
                    end
                    S_RD1: if (done) begin
                        d_wrap <= mem_rdata[31];  d_chain <= mem_rdata[30];
                        sz2w   <= mem_rdata[28:18];  sz1w <= mem_rdata[12:2];
                        st     <= S_RD2;
                    end
                    S_RD2: if (done) begin b1a <= mem_rdata[AW-1:0]; st <= S_RD3; end
                    S_RD3: if (done) begin
                        b2a <= mem_rdata[AW-1:0];
                        off <= '0;  wptr <= '0;  lane <= '0;
                        first_seg <= !mid;
                        st <= S_RUN;
                    end
                    S_RUN: if (accept) begin
                        lane <= lane + 2'd1;
                        off  <= off + LEN_W'(1);
                        if (lane == 2'd0) wbuf <= {24'd0, in_data};
                        else              wbuf[{lane, 3'b000} +: 8] <= in_data;
                        if (in_sof) begin
                            mid <= 1'b1;  flen <= LEN_W'(1);  ts_cap <= ts_value;
                        end else begin
                            flen <= flen + LEN_W'(1);
                        end
                        if (in_eof) begin
                            eof_seen <= 1'b1;
                            ts_q     <= ts_enable && in_ts_hit;
                        end
                        if (word_end) st <= S_WRB;
                    end
                    S_WRB: if (done) begin
                        lane <= '0;
                        wptr <= off;
                        if (eof_seen)        st <= ts_q ? S_TS2 : S_CL0;
                        else if (off == cap) st <= S_CL0;
                        else                 st <= S_RUN;
                    end
                    S_TS2: if (done) st <= S_TS3;
                    S_TS3: if (done) st <= S_CL0;
                    S_CL0: if (done) begin
                        cur <= nxt;
                        if (eof_seen) mid <= 1'b0;
                        eof_seen <= 1'b0;
                        st <= S_RD0;
                    end
                    S_SUSP: if (poll_kick || (in_valid && in_sof && !mid)) begin
                        buf_unavail <= 1'b0;
                        st <= S_RD0;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R12: a pending access keeps its command until granted
    a_r12_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R12: byte intake and memory traffic never overlap
    a_r12_intake_quiet: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !mem_req);

    // R2: a host-owned word 0 leads to the unavailable flag
    a_r2_unowned_parks: assert property (@(posedge clk) disable iff (rst)
        (st == S_RD0 && mem_gnt && !mem_rdata[31] && run_en) |=> buf_unavail);

    // R5: every buffer write lies inside the descriptor capacity
    a_r5_write_in_capacity: assert property (@(posedge clk) disable iff (rst)
        (st == S_WRB) |-> (wptr < cap));

    // R10: with the start bit low and nothing pending, the engine goes quiet
    a_r10_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !mem_req) |=> (!in_ready && !mem_req && !buf_unavail));

endmodule

// File: tb/test_rx_desc_dma.sv
module test_rx_desc_dma;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0, poll_kick = 1'b0, ts_enable = 1'b0;
    logic [31:0] list_base = '0;
    logic [63:0] ts_value = '0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_ts_hit = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, mem_req, mem_we, buf_unavail;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_gnt = 1'b0;

    logic [31:0] mem [0:255];
    logic        h_we = 1'b0;
    logic [31:0] h_addr = '0, h_data = '0;
    logic [7:0]  fb [0:63];
    int          nchk = 0, nfail = 0, r12_bad = 0;
    logic        p_wait = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0;

    always #10 clk = ~clk;

    rx_desc_dma i_rx_desc_dma (
        .clk(clk), .rst(rst), .run_en(run_en), .poll_kick(poll_kick),
        .ts_enable(ts_enable), .list_base(list_base), .ts_value(ts_value),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ts_hit(in_ts_hit), .in_ready(in_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .buf_unavail(buf_unavail)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else if (mem_req && mem_we && mem_gnt) begin
            mem[mem_addr[9:2]] <= mem_wdata;
        end else if (h_we) begin
            mem[h_addr[9:2]] <= h_data;
        end
    end

    // random grant plus R12 command-hold monitor
    always @(negedge clk) begin
        if (!rst && p_wait && (!mem_req || mem_addr != p_addr || mem_we != p_we))
            r12_bad = r12_bad + 1;
        mem_gnt = ($urandom_range(3) != 0);
        p_wait  = mem_req && !mem_gnt && !rst;
        p_addr  = mem_addr;
        p_we    = mem_we;
    end

    function automatic logic [31:0] ew0(input int len, input bit f, input bit l, input bit t);
        return {2'b00, 14'(len), 6'd0, f, l, t, 7'd0};
    endfunction

    function automatic logic [31:0] ew1(input bit eor, input bit ch, input int s2, input int s1);
        return {eor, ch, 1'b0, 13'(s2), 3'd0, 13'(s1)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_word(input int addr, input logic [31:0] exp, input string tag);
        chk(mem[addr >> 2] == exp, tag, mem[addr >> 2], exp);
    endtask

    task automatic chk_buf(input int addr, input int fbase, input int cnt, input string tag);
        for (int j = 0; j * 4 < cnt; j++) begin
            logic [31:0] e;
            e = '0;
            for (int k = 0; k < 4; k++)
                if (j * 4 + k < cnt) e[8*k +: 8] = fb[fbase + j*4 + k];
            chk_word(addr + 4*j, e, tag);
        end
    endtask

    task automatic hwr(input int addr, input logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_addr = 32'(addr); h_data = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input bit q);
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b0;
            repeat ($urandom_range(2)) @(negedge clk);
            in_valid = 1'b1; in_data = fb[i];
            in_sof = (i == 0); in_eof = (i == len - 1); in_ts_hit = q;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_ts_hit = 1'b0;
    endtask

    task automatic set_desc(input int a, input logic [31:0] w0, input logic [31:0] w1,
                            input int b1, input int b3);
        hwr(a, w0); hwr(a + 4, w1); hwr(a + 8, 32'(b1)); hwr(a + 12, 32'(b3));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
        $finish;
    end

    initial begin : main
        logic [63:0] tsv;
        void'($urandom(32'h1a2b3c4d));
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !in_ready && !buf_unavail, "R10 reset idle",
            {29'd0, mem_req, in_ready, buf_unavail}, 32'd0);

        // ring of four; desc1 size field 18 -> 16 usable (R11)
        set_desc(32'h000, 32'h8000_0000, ew1(0,0,8,16), 32'h100, 32'h140);
        set_desc(32'h010, 32'h8000_0000, ew1(0,0,8,18), 32'h180, 32'h1C0);
        set_desc(32'h020, 32'h8000_0000, ew1(0,0,8,16), 32'h200, 32'h240);
        set_desc(32'h030, 32'h0000_0000, ew1(1,0,8,16), 32'h280, 32'h2C0);
        list_base = 32'h0;
        run_en = 1'b1;
        wait_cyc(30);
        chk(in_ready == 1'b1, "R1 owned descriptor accepts bytes", {31'd0, in_ready}, 32'd1);

        // frame A: 10 bytes, one descriptor, padded tail
        send_frame(10, 1'b0);
        wait_cyc(60);
        chk_buf(32'h100, 0, 10, "R11 packing frame A");
        chk_word(32'h000, ew0(10,1,1,0), "R7 close frame A");

        // frame B: 30 bytes, spill 24 -> 6
        send_frame(30, 1'b0);
        wait_cyc(60);
        chk_buf(32'h180, 0, 16, "R5 buffer1 of spill");
        chk_buf(32'h1C0, 16, 8, "R5 buffer2 of spill");
        chk_word(32'h010, ew0(0,1,0,0), "R6 spilled descriptor close");
        chk_buf(32'h200, 24, 6, "R6 continuation bytes");
        chk_word(32'h020, ew0(30,0,1,0), "R7 last segment length");
        chk(buf_unavail == 1'b1, "R2 parked on host descriptor", {31'd0, buf_unavail}, 32'd1);
        chk_word(32'h030, 32'h0, "R2 host descriptor untouched");
        chk(in_ready == 1'b0, "R2 no intake while parked", {31'd0, in_ready}, 32'd0);

        // hand desc3 over, poll
        hwr(32'h030, 32'h8000_0000);
        @(negedge clk); poll_kick = 1'b1;
        @(negedge clk); poll_kick = 1'b0;
        wait_cyc(25);
        chk(!buf_unavail && in_ready, "R3 poll resumes", {30'd0, buf_unavail, in_ready}, 32'd1);

        // frame C with timestamp
        ts_enable = 1'b1;
        tsv = {$urandom, $urandom};
        ts_value = tsv;
        send_frame(5, 1'b1);
        ts_value = ~tsv;
        wait_cyc(60);
        chk_buf(32'h280, 0, 5, "R11 frame C bytes");
        chk_word(32'h038, tsv[31:0], "R8 timestamp low");
        chk_word(32'h03C, tsv[63:32], "R8 timestamp high");
        chk_word(32'h030, ew0(5,1,1,1), "R8 status with timestamp flag");
        chk(buf_unavail == 1'b1, "R9 wrap reaches closed desc0", {31'd0, buf_unavail}, 32'd1);

        // give back desc0, wake by new frame only
        hwr(32'h000, 32'h8000_0000);
        send_frame(8, 1'b0);
        wait_cyc(60);
        chk_buf(32'h100, 0, 8, "R4 frame D after sof wake");
        chk_word(32'h000, ew0(8,1,1,0), "R9 ring wrap landed in desc0");
        chk_word(32'h008, 32'h100, "R8 no timestamp when not qualified");

        // stop
        run_en = 1'b0;
        wait_cyc(10);
        chk(!in_ready && !mem_req && !buf_unavail, "R10 stop idle",
            {29'd0, in_ready, mem_req, buf_unavail}, 32'd0);

        // chain mode: 12-byte buffers, buffer2 size ignored
        set_desc(32'h300, 32'h8000_0000, ew1(0,1,8,12), 32'h380, 32'h340);
        set_desc(32'h340, 32'h8000_0000, ew1(0,1,8,12), 32'h3A0, 32'h360);
        list_base = 32'h300;
        run_en = 1'b1;
        wait_cyc(5);
        send_frame(20, 1'b0);
        wait_cyc(60);
        chk_buf(32'h380, 0, 12, "R5 chain buffer1 only");
        chk_word(32'h300, ew0(0,1,0,0), "R5 chain capacity spill");
        chk_buf(32'h3A0, 12, 8, "R9 chain pointer followed");
        chk_word(32'h340, ew0(20,1'b0,1,0), "R7 chain last segment");
        chk(buf_unavail == 1'b1, "R9 chain next from word 3", {31'd0, buf_unavail}, 32'd1);

        chk(r12_bad == 0, "R12 command held until grant", 32'(r12_bad), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule